// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, once per cycle, which hardware thread of a multithreaded core may use the instruction-fetch path. Each thread reports its fetch state as a three-bit code. Only a few of those states allow the thread to compete. A three-bit policy input picks the arbitration rule:

- a fixed single-thread rule;
- a rotating priority list;
- a ranking by per-thread instruction-queue or load/store-queue occupancy.

The status, policy and occupancy inputs are captured in registers on every clock edge. The grant is formed combinationally from those registers and from the rotating priority list.

The priority list is held inside the block. It changes only when the rotating rule actually grants a thread. Software or the core may switch policies at run time, and the rotation order is kept while a counting rule is in force. The consumer reads a valid flag and a thread number in the cycle after it presents the inputs.

Top module: `fetch_thread_pick`

## Requirements
- R1: The status codes are Running=0, Idle=1, Squashing=2, Blocked=3, WaitResponse=4, WaitRetry=5, CacheDone=6 and Quiesced=7. Only codes 0, 1 and 6 make a thread eligible; a grant under a scanning or counting policy never goes to a thread with any other code.
- R2: Under policy 1 (rotate), the priority list is searched from its head slot, and the first eligible thread found is granted.
- R3: After a rotate grant, the granted thread moves to the tail slot and the threads that followed it move up one slot, keeping their relative order. Grants under any other policy leave the list untouched.
- R4: When no thread is eligible under rotate or a counting policy, grant_vld_o is 0 and the priority list is unchanged.
- R5: Under policy 0 (single-thread) with more than one thread, thread 0 is granted every cycle, whatever its status.
- R6: With NUM_THR = 1, thread 0 is granted exactly when its status is eligible, under every policy code.
- R7: Reset sets the priority list to ascending thread numbers and every captured status to Blocked, so no grant is shown until inputs are captured.
- R8: With more than one thread, policy 2 (branch-count, not supported) and the codes 5 to 7 never produce a grant.
- R9: Under policy 3 (instruction-queue count) or policy 4 (load/store-queue count), the eligible thread with the smallest occupancy of the selected queue is granted. Ties go to the lower thread number.
- R10: Inputs presented before a clock edge determine the grant seen after that edge and until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| status_i | input | 3*NUM_THR | Fetch state per thread; thread t at bits [3t+2:3t] |
| policy_i | input | 3 | Arbitration rule code |
| iq_occ_i | input | OCC_W*NUM_THR | Instruction-queue occupancy per thread; thread t at bits [OCC_W*t +: OCC_W] |
| lsq_occ_i | input | OCC_W*NUM_THR | Load/store-queue occupancy per thread, same packing |
| grant_vld_o | output | 1 | A thread is granted this cycle |
| grant_tid_o | output | max(1,clog2(NUM_THR)) | Granted thread number; 0 when no grant |

## Verification
A rotate grant that reorders the priority list and a newly captured policy or status vector take effect on the same clock edge. The next grant must use both the new inputs and the freshly rotated list. The bench provokes this by changing policy in consecutive cycles: rotate, counting, branch and back to rotate, both in directed runs and in thousands of random cycles. It judges each grant against a reference list model that is advanced only after a rotate grant.

// File: rtl/ftp_pkg.sv
package ftp_pkg;

    localparam logic [2:0] FS_RUN        = 3'd0;
    localparam logic [2:0] FS_IDLE       = 3'd1;
    localparam logic [2:0] FS_SQUASH     = 3'd2;
    localparam logic [2:0] FS_BLOCK      = 3'd3;
    localparam logic [2:0] FS_WAIT_RESP  = 3'd4;
    localparam logic [2:0] FS_WAIT_RETRY = 3'd5;
    localparam logic [2:0] FS_IC_DONE    = 3'd6;
    localparam logic [2:0] FS_QUIESCE    = 3'd7;

    localparam logic [2:0] SEL_SINGLE = 3'd0;
    localparam logic [2:0] SEL_ROTATE = 3'd1;
    localparam logic [2:0] SEL_BRANCH = 3'd2;
    localparam logic [2:0] SEL_IQ     = 3'd3;
    localparam logic [2:0] SEL_LSQ    = 3'd4;

    function automatic logic fs_can_fetch(logic [2:0] s);
        return (s == FS_RUN) || (s == FS_IDLE) || (s == FS_IC_DONE);
    endfunction

endpackage

// File: rtl/ftp_elig.sv
module ftp_elig #(
    parameter int NUM_THR = 4
) (
    input  logic [NUM_THR-1:0][2:0] stat,
    output logic [NUM_THR-1:0]      elig
);
    import ftp_pkg::*;

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        assign elig[t] = fs_can_fetch(stat[t]);
    end

endmodule

// File: rtl/ftp_rr_pick.sv
module ftp_rr_pick #(
    parameter int NUM_THR = 4,
    parameter int TW      = 2
) (
    input  logic [NUM_THR-1:0]         elig,
    input  logic [NUM_THR-1:0][TW-1:0] order,
    output logic                       found,
    output logic [TW-1:0]              tid,
    output logic [TW-1:0]              pos
);

    always_comb begin
        found = 1'b0;
        tid   = '0;
        pos   = '0;
        // walk from the tail toward the head so the head-most hit wins
        for (int i = NUM_THR - 1; i >= 0; i--) begin
            if (elig[order[i]]) begin
                found = 1'b1;
                tid   = order[i];
                pos   = TW'(i);
            end
        end
    end

endmodule

// File: rtl/ftp_occ_pick.sv
module ftp_occ_pick #(
    parameter int NUM_THR = 4,
    parameter int TW      = 2,
    parameter int OCC_W   = 6
) (
    input  logic [NUM_THR-1:0]            elig,
    input  logic [NUM_THR-1:0][OCC_W-1:0] occ,
    output logic                          found,
    output logic [TW-1:0]                 tid
);
    logic [OCC_W-1:0] best;

    always_comb begin
        found = 1'b0;
        tid   = '0;
        best  = '0;
        // strict less-than in ascending order keeps the lower id on ties
        for (int i = 0; i < NUM_THR; i++) begin
            if (elig[i] && (!found || occ[i] < best)) begin
                found = 1'b1;
                best  = occ[i];
                tid   = TW'(i);
            end
        end
    end

endmodule

// File: rtl/ftp_order_rot.sv
module ftp_order_rot #(
    parameter int NUM_THR = 4,
    parameter int TW      = 2
) (
    input  logic [NUM_THR-1:0][TW-1:0] order_in,
    input  logic [TW-1:0]              pos,
    input  logic [TW-1:0]              tid,
    output logic [NUM_THR-1:0][TW-1:0] order_out
);

    for (genvar i = 0; i < NUM_THR; i++) begin : g_slot
        if (i == NUM_THR - 1) begin : g_tail
            assign order_out[i] = tid;
        end else begin : g_body
            assign order_out[i] = (TW'(i) < pos) ? order_in[i] : order_in[i+1];
        end
    end

endmodule

// File: rtl/fetch_thread_pick.sv
module fetch_thread_pick #(
    parameter  int NUM_THR = 4,
    parameter  int OCC_W   = 6,
    localparam int TW      = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [3*NUM_THR-1:0]       status_i,
    input  logic [2:0]                 policy_i,
    input  logic [OCC_W*NUM_THR-1:0]   iq_occ_i,
    input  logic [OCC_W*NUM_THR-1:0]   lsq_occ_i,
    output logic                       grant_vld_o,
    output logic [TW-1:0]              grant_tid_o
);
    import ftp_pkg::*;

    typedef struct packed {
        logic [NUM_THR-1:0][2:0]       stat;
        logic [2:0]                    pol;
        logic [NUM_THR-1:0][OCC_W-1:0] iq;
        logic [NUM_THR-1:0][OCC_W-1:0] lsq;
        logic [NUM_THR-1:0][TW-1:0]    order;
    } sel_state_t;

    sel_state_t st_d, st_q;

    logic [NUM_THR-1:0]            elig_w;
    logic                          rr_found, occ_found;
    logic [TW-1:0]                 rr_tid, rr_pos, occ_tid;
    logic [NUM_THR-1:0][OCC_W-1:0] occ_sel;
    logic [NUM_THR-1:0][TW-1:0]    order_rot;
    logic                          gv_w;
    logic [TW-1:0]                 gt_w;

    ftp_elig #(.NUM_THR(NUM_THR)) u_elig (
        .stat (st_q.stat),
        .elig (elig_w)
    );

    ftp_rr_pick #(.NUM_THR(NUM_THR), .TW(TW)) u_rr (
        .elig  (elig_w),
        .order (st_q.order),
        .found (rr_found),
        .tid   (rr_tid),
        .pos   (rr_pos)
    );

    assign occ_sel = (st_q.pol == SEL_LSQ) ? st_q.lsq : st_q.iq;

    ftp_occ_pick #(.NUM_THR(NUM_THR), .TW(TW), .OCC_W(OCC_W)) u_occ (
        .elig  (elig_w),
        .occ   (occ_sel),
        .found (occ_found),
        .tid   (occ_tid)
    );

    ftp_order_rot #(.NUM_THR(NUM_THR), .TW(TW)) u_rot (
        .order_in  (st_q.order),
        .pos       (rr_pos),
        .tid       (rr_tid),
        .order_out (order_rot)
    );

    always_comb begin
        gv_w = 1'b0;
        gt_w = '0;
        if (NUM_THR == 1) begin
            gv_w = elig_w[0];
        end else begin
            case (st_q.pol)
                SEL_SINGLE: begin
                    gv_w = 1'b1;
                end
                SEL_ROTATE: begin
                    gv_w = rr_found;
                    gt_w = rr_found ? rr_tid : '0;
                end
                SEL_IQ, SEL_LSQ: begin
                    gv_w = occ_found;
                    gt_w = occ_found ? occ_tid : '0;
                end
                default: begin
                    gv_w = 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.stat = status_i;
        st_d.pol  = policy_i;
        st_d.iq   = iq_occ_i;
        st_d.lsq  = lsq_occ_i;
        if ((NUM_THR > 1) && gv_w && (st_q.pol == SEL_ROTATE)) begin
            st_d.order = order_rot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_THR; t++) begin
                st_q.stat[t]  <= FS_BLOCK;
                st_q.order[t] <= TW'(t);
                st_q.iq[t]    <= '0;
                st_q.lsq[t]   <= '0;
            end
            st_q.pol <= SEL_ROTATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_vld_o = gv_w;
    assign grant_tid_o = gt_w;

endmodule

// File: rtl/ftp_checker.sv
module ftp_checker #(
    parameter int NUM_THR = 4,
    parameter int TW      = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_THR-1:0]      elig,
    input logic [2:0]              pol,
    input logic [NUM_THR*TW-1:0]   order_flat,
    input logic                    gv,
    input logic [TW-1:0]           gt
);
    import ftp_pkg::*;

    if (NUM_THR > 1) begin : g_multi
        // R1: scanning and counting rules only pick eligible threads
        p_pick_eligible_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (gv && pol != SEL_SINGLE) |-> elig[gt]);

        // R3: a rotate grant puts the winner in the tail slot
        p_winner_to_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (gv && pol == SEL_ROTATE) |=> order_flat[NUM_THR*TW-1 -: TW] == $past(gt));

        // R4: with nobody eligible there is no grant
        p_none_no_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (elig == '0 && pol != SEL_SINGLE) |-> !gv);

        // R4: no grant leaves the list alone
        p_order_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !gv |=> $stable(order_flat));

        // R5: single-thread rule always grants thread 0
        p_single_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (pol == SEL_SINGLE) |-> (gv && gt == '0));

        // R8: branch code and unused codes yield nothing
        p_branch_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (pol == SEL_BRANCH || pol > SEL_LSQ) |-> !gv);
    end else begin : g_one
        // R6: a lone thread is granted exactly when eligible
        p_lone_thread_r6: assert property (@(posedge clk) disable iff (!rst_n)
            gv == elig[0]);
    end

endmodule

bind fetch_thread_pick ftp_checker #(.NUM_THR(NUM_THR), .TW(TW)) u_ftp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .elig       (elig_w),
    .pol        (st_q.pol),
    .order_flat (st_q.order),
    .gv         (grant_vld_o),
    .gt         (grant_tid_o)
);

// File: tb/sim_fetch_thread_pick.sv
`timescale 1ns/1ps
module sim_fetch_thread_pick;

    localparam int N  = 4;
    localparam int OW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3*N-1:0]  st = '0;
    logic [2:0]      pol = 3'd1;
    logic [OW*N-1:0] iq = '0;
    logic [OW*N-1:0] lsq = '0;
    logic [2:0]      st1 = 3'd3;
    logic [2:0]      pol1 = 3'd0;
    logic [OW-1:0]   iq1 = '0;
    logic            gv0, gv1;
    logic [1:0]      gt0;
    logic            gt1;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    int m_order [N];

    always #4 clk = ~clk;

    fetch_thread_pick #(.NUM_THR(N), .OCC_W(OW)) u0 (
        .clk(clk), .rst_n(rst_n), .status_i(st), .policy_i(pol),
        .iq_occ_i(iq), .lsq_occ_i(lsq), .grant_vld_o(gv0), .grant_tid_o(gt0)
    );

    fetch_thread_pick #(.NUM_THR(1), .OCC_W(OW)) u1 (
        .clk(clk), .rst_n(rst_n), .status_i(st1), .policy_i(pol1),
        .iq_occ_i(iq1), .lsq_occ_i(iq1), .grant_vld_o(gv1), .grant_tid_o(gt1)
    );

    function automatic bit can_go(logic [2:0] s);
        return (s == 3'd0) || (s == 3'd1) || (s == 3'd6);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference selection from the requirement text
    task automatic apply(logic [3*N-1:0] s, logic [2:0] p,
                         logic [OW*N-1:0] q, logic [OW*N-1:0] l,
                         logic [2:0] s1, logic [2:0] p1, string tag);
        bit ev; int et; int epos; int best;
        st = s; pol = p; iq = q; lsq = l; st1 = s1; pol1 = p1;
        @(posedge clk);
        @(negedge clk);
        ev = 0; et = 0; epos = 0; best = 0;
        if (p == 3'd0) begin
            ev = 1;
        end else if (p == 3'd1) begin
            for (int i = 0; i < N; i++)
                if (!ev && can_go(s[3*m_order[i] +: 3])) begin
                    ev = 1; et = m_order[i]; epos = i;
                end
        end else if (p == 3'd3 || p == 3'd4) begin
            for (int i = 0; i < N; i++) begin
                int o;
                o = (p == 3'd3) ? int'(q[OW*i +: OW]) : int'(l[OW*i +: OW]);
                if (can_go(s[3*i +: 3]) && (!ev || o < best)) begin
                    ev = 1; et = i; best = o;
                end
            end
        end
        check({tag, " valid"}, int'(gv0), int'(ev));
        check({tag, " tid"}, int'(gt0), et);
        check("R6 lone thread valid", int'(gv1), int'(can_go(s1)));
        check("R6 lone thread tid", int'(gt1), 0);
        if (ev && p == 3'd1) begin
            for (int i = epos; i < N - 1; i++) m_order[i] = m_order[i+1];
            m_order[N-1] = et;
        end
    endtask

    function automatic logic [3*N-1:0] all_st(logic [2:0] v);
        return {N{v}};
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < N; i++) m_order[i] = i;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R7 reset no grant", int'(gv0), 0);
        check("R7 reset lone no grant", int'(gv1), 0);

        // R7/R2/R3: ascending start then rotation
        for (int k = 0; k < 5; k++)
            apply(all_st(3'd0), 3'd1, '0, '0, 3'd0, 3'd1, "R2 R3 R7 rotate all");
        // R2: single eligible
        apply({3'd3, 3'd0, 3'd3, 3'd3}, 3'd1, '0, '0, 3'd1, 3'd2, "R2 only thread2");
        // R4: none eligible, then order unchanged
        apply(all_st(3'd4), 3'd1, '0, '0, 3'd5, 3'd1, "R4 none eligible");
        apply(all_st(3'd2), 3'd3, '0, '0, 3'd6, 3'd3, "R4 none eligible count");
        apply(all_st(3'd1), 3'd1, '0, '0, 3'd6, 3'd1, "R4 order kept");
        // R5: single ignores status
        apply(all_st(3'd3), 3'd0, '0, '0, 3'd3, 3'd0, "R5 single blocked");
        // R8: branch and spare codes
        apply(all_st(3'd0), 3'd2, '0, '0, 3'd0, 3'd2, "R8 branch");
        apply(all_st(3'd0), 3'd7, '0, '0, 3'd0, 3'd7, "R8 spare code");
        // R9: ties toward lower id
        apply(all_st(3'd0), 3'd3, {4'd5, 4'd1, 4'd1, 4'd3}, '0, 3'd0, 3'd3, "R9 iq tie");
        apply({3'd6, 3'd0, 3'd2, 3'd1}, 3'd4, '0, {4'd9, 4'd2, 4'd0, 4'd7}, 3'd0, 3'd4,
              "R9 lsq skip ineligible");
        // R1: every status code on thread 1 alone
        for (int c = 0; c < 8; c++)
            apply({3'd3, 3'd3, 3'(c), 3'd3}, 3'd1, '0, '0, 3'(c), 3'd1, "R1 status sweep");
        // R3 R10: switch policy each cycle around rotate grants
        apply(all_st(3'd0), 3'd1, '0, '0, 3'd0, 3'd1, "R10 rotate");
        apply(all_st(3'd0), 3'd3, {4'd0, 4'd9, 4'd9, 4'd9}, '0, 3'd0, 3'd3, "R3 count keeps order");
        apply(all_st(3'd0), 3'd1, '0, '0, 3'd0, 3'd1, "R3 R10 back to rotate");

        for (int k = 0; k < 4000; k++) begin
            logic [3*N-1:0] rs;
            logic [2:0] rp;
            for (int t = 0; t < N; t++)
                rs[3*t +: 3] = ($urandom % 2 == 0) ? 3'(($urandom % 2) * 6) : 3'($urandom % 8);
            rp = ($urandom % 3 == 0) ? 3'($urandom % 8) : 3'(1 + 2 * ($urandom % 2));
            apply(rs, rp, OW*N'($urandom), OW*N'($urandom & 32'h3333),
                  3'($urandom % 8), 3'($urandom % 8), "R1 R2 R3 R9 random");
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule